// File: doc/BRIEF.md
# Addressing-Mode Effective Address Unit

This unit computes the 16-bit data address for an operand of an 8-bit processor. It takes a mode code, one or two operand bytes and the two index registers X and Y. Direct modes come from a single addition, and their result is returned one cycle after the start pulse. The three pointer-based modes first read a low and a high pointer byte from page memory through a byte-wide synchronous read port. They finish once both bytes have arrived. Each zero-page sum follows the wrap rule of its own mode.

A thin bypass handles operands that live outside memory. Accumulator operands return the A register. Immediate reads return operand byte 1. Neither of these touches the bus. Illegal combinations raise an error flag in place of an address: an immediate write, the three modes that only change the program counter, or the reserved code. Each calculation ends with a one-cycle done pulse. The results then stay unchanged until the next start.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode codes 0 (zero page) and 1 (zero-page bit test) give ea = {8'h00, op1}.
- R2: Mode 2 (zero page plus X) gives ea = {8'h00, (op1 + X) mod 256}, so the high byte is always zero.
- R3: Mode 3 (zero page plus Y) gives ea = op1 + Y computed at 16 bits, so op1=FF, Y=01 gives 0x0100.
- R4: Mode 4 (absolute) gives ea = {op2, op1}. Modes 5 and 6 add X or Y to that value modulo 2^16.
- R5: Mode 7 (pointer in page zero) reads the pointer low byte at op1 and the high byte at op1+1 as a 16-bit sum (op1=FF reads 0x0100). ea is the pointer {hi, lo}.
- R6: Mode 8 (X-indexed pointer) reads the low byte at (op1+X) mod 256 and the high byte at (op1+X+1) mod 256. ea is the pointer.
- R7: Mode 9 (pointer then Y) reads the pointer at op1 and op1+1 as in R5. ea is pointer + Y modulo 2^16.
- R8: Mode 10 (accumulator) sets direct=1 and direct_val=A for both reads and writes. Mode 11 (immediate) read sets direct=1 and direct_val=op1. In both cases ea=0 and err=0.
- R9: An immediate write (mode 11, wr=1), modes 12, 13, 14 and the reserved code 15 set err=1, ea=0 and direct=0.
- R10: Only the pointer modes drive mem_rd. They assert it for the two cycles that follow the start edge, with the low-byte address first and then the high-byte address. Read data is taken from mem_data in the cycle after each request. done pulses in the fourth cycle after the start edge. For all other modes, done pulses in the first cycle after the start edge.
- R11: start is sampled only while the unit is idle. done is a one-cycle pulse. ea, err, direct and direct_val stay unchanged from done until the next accepted start.
- R12: After reset, done, err, direct and mem_rd are 0, and ea and direct_val are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a calculation when idle |
| wr | input | 1 | Operand is a write target |
| mode | input | 4 | Addressing mode code |
| op1 | input | 8 | Operand byte 1 |
| op2 | input | 8 | Operand byte 2 |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| acc | input | 8 | Accumulator value |
| mem_rd | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| mem_data | input | 8 | Read data, valid the cycle after a request |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| err | output | 1 | Mode has no data address |
| direct | output | 1 | Operand bypasses memory |
| direct_val | output | 8 | Bypassed operand value |

## Verification
The bench drives sums that cross a page boundary. It sets op1=FF with a nonzero X or Y: a design that treated zero page plus Y like zero page plus X would drop the carry into page one, and one that forgot the X wrap would leave page zero. For the pointer modes it sets op1=FF so that the high-byte fetch lands on the boundary, which tells 0x0100 (pointer at op1 and op1+1) apart from 0x0000 (X-indexed wrap); a swapped byte order or a misplaced Y addition then shows up as a wrong ea. A second start is pulsed while the unit is busy, and the inputs are changed after done. A unit that accepted the pulse, or that let its results follow the inputs, would then show extra bus reads or a changed ea.

// File: rtl/eff_addr_unit.sv
module eff_addr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr,
  input  logic [3:0]  mode,
  input  logic [7:0]  op1,
  input  logic [7:0]  op2,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic [7:0]  acc,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_data,
  output logic        done,
  output logic [15:0] ea,
  output logic        err,
  output logic        direct,
  output logic [7:0]  direct_val
);
  localparam logic [3:0] M_ZP = 4'd0, M_ZPB = 4'd1, M_ZPX = 4'd2, M_ZPY = 4'd3;
  localparam logic [3:0] M_ABS = 4'd4, M_ABSX = 4'd5, M_ABSY = 4'd6;
  localparam logic [3:0] M_IZP = 4'd7, M_IZPX = 4'd8, M_IZPY = 4'd9;
  localparam logic [3:0] M_ACC = 4'd10, M_IMM = 4'd11;

  typedef enum logic [1:0] {S_IDLE, S_REQ_LO, S_REQ_HI, S_FIN} state_t;
  state_t st;

  logic [3:0]  m_q;
  logic [7:0]  op1_q, x_q, y_q, lo_q;
  logic [15:0] d_ea;
  logic        d_err, d_dir, indir;
  logic [7:0]  d_val;

  always_comb begin
    d_ea = 16'h0000; d_err = 1'b0; d_dir = 1'b0; d_val = 8'h00; indir = 1'b0;
    case (mode)
      M_ZP, M_ZPB: d_ea = {8'h00, op1};
      M_ZPX:       d_ea = {8'h00, 8'(op1 + idx_x)};
      M_ZPY:       d_ea = {8'h00, op1} + {8'h00, idx_y};
      M_ABS:       d_ea = {op2, op1};
      M_ABSX:      d_ea = {op2, op1} + {8'h00, idx_x};
      M_ABSY:      d_ea = {op2, op1} + {8'h00, idx_y};
      M_IZP, M_IZPX, M_IZPY: indir = 1'b1;
      M_ACC:       begin d_dir = 1'b1; d_val = acc; end
      M_IMM:       if (wr) d_err = 1'b1; else begin d_dir = 1'b1; d_val = op1; end
      default:     d_err = 1'b1;
    endcase
  end

  wire [15:0] ptr_lo = (m_q == M_IZPX) ? {8'h00, 8'(op1_q + x_q)} : {8'h00, op1_q};
  wire [15:0] ptr_hi = (m_q == M_IZPX) ? {8'h00, 8'(op1_q + x_q + 8'd1)}
                                       : {8'h00, op1_q} + 16'd1;

  assign mem_rd   = (st == S_REQ_LO) || (st == S_REQ_HI);
  assign mem_addr = (st == S_REQ_HI) ? ptr_hi : ptr_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; m_q <= 4'd0; op1_q <= 8'h00; x_q <= 8'h00; y_q <= 8'h00;
      lo_q <= 8'h00; done <= 1'b0; ea <= 16'h0000; err <= 1'b0;
      direct <= 1'b0; direct_val <= 8'h00;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m_q <= mode; op1_q <= op1; x_q <= idx_x; y_q <= idx_y;
          if (indir) st <= S_REQ_LO;
          else begin
            done <= 1'b1; ea <= d_ea; err <= d_err;
            direct <= d_dir; direct_val <= d_val;
          end
        end
        S_REQ_LO: st <= S_REQ_HI;
        S_REQ_HI: begin lo_q <= mem_data; st <= S_FIN; end
        default: begin
          done <= 1'b1; err <= 1'b0; direct <= 1'b0; direct_val <= 8'h00;
          ea <= {mem_data, lo_q} + ((m_q == M_IZPY) ? {8'h00, y_q} : 16'h0000);
          st <= S_IDLE;
        end
      endcase
    end
  end

  AST_ZPX_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && mode == M_ZPX) |=> (ea[15:8] == 8'h00 && done)); // R2
  AST_PTRX_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && m_q == M_IZPX) |-> (mem_addr[15:8] == 8'h00)); // R6
  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (ea == 16'h0000 && !direct)); // R9
  AST_DIRECT_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !indir) |=> (done && !mem_rd)); // R10
  AST_RD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> mem_rd); // R10
  AST_RD_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |=> done); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(ea) && $stable(err) && $stable(direct)
                                  && $stable(direct_val))); // R11
endmodule

// File: tb/test_eff_addr_unit.sv
module test_eff_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [7:0] op1 = 0, op2 = 0, idx_x = 0, idx_y = 0, acc = 0, mem_data = 0;
  logic mem_rd, done, err, direct;
  logic [15:0] mem_addr, ea;
  logic [7:0] direct_val;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eff_addr_unit i_eff_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .mode(mode), .op1(op1),
    .op2(op2), .idx_x(idx_x), .idx_y(idx_y), .acc(acc), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .done(done), .ea(ea), .err(err),
    .direct(direct), .direct_val(direct_val));

  function automatic int memfn(input int a);
    return ((a % 256) * 7 + (a / 256) * 13 + 60) % 256;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= 8'(memfn(int'(mem_addr)));

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int m, input int w);
    case (m)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4, 5, 6: return "R4";
      7: return "R5";
      8: return "R6";
      9: return "R7";
      10: return "R8";
      11: return w ? "R9" : "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_op(input int m, input int w, input int o1, input int o2,
                        input int x, input int y, input int a, input bit busy);
    int e_ea = 0, e_err = 0, e_dir = 0, e_val = 0, plo = 0, phi = 0;
    bit ind;
    string t;
    t = tag_of(m, w);
    ind = (m >= 7 && m <= 9);
    case (m)
      0, 1: e_ea = o1;
      2: e_ea = (o1 + x) % 256;
      3: e_ea = o1 + y;
      4: e_ea = o2 * 256 + o1;
      5: e_ea = (o2 * 256 + o1 + x) % 65536;
      6: e_ea = (o2 * 256 + o1 + y) % 65536;
      7, 9: begin plo = o1; phi = o1 + 1; end
      8: begin plo = (o1 + x) % 256; phi = (o1 + x + 1) % 256; end
      10: begin e_dir = 1; e_val = a; end
      11: if (w != 0) e_err = 1; else begin e_dir = 1; e_val = o1; end
      default: e_err = 1;
    endcase
    if (ind) e_ea = (memfn(phi) * 256 + memfn(plo) + (m == 9 ? y : 0)) % 65536;
    @(negedge clk);
    mode = 4'(m); wr = w[0]; op1 = 8'(o1); op2 = 8'(o2);
    idx_x = 8'(x); idx_y = 8'(y); acc = 8'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      int exp_done, exp_rd;
      exp_done = ind ? (n == 4) : (n == 1);
      exp_rd = ind && (n <= 2);
      chk("R10", "done", int'(done), exp_done);
      chk("R10", "mem_rd", int'(mem_rd), exp_rd);
      if (exp_rd != 0) chk(t, "mem_addr", int'(mem_addr), n == 1 ? plo : phi);
      if (n >= (ind ? 4 : 1)) begin
        chk(n > (ind ? 4 : 1) ? "R11" : t, "ea", int'(ea), e_ea);
        chk(t, "err", int'(err), e_err);
        chk(t, "direct", int'(direct), e_dir);
        chk(t, "direct_val", int'(direct_val), e_val);
      end
      if (busy && n == 1) begin mode = 4'd4; op1 = 8'h12; op2 = 8'h34; start = 1'b1; end
      if (n == 2) begin start = 1'b0; mode = 4'd15; op1 = ~op1; idx_x = ~idx_x; end
      @(negedge clk);
    end
    chk("R11", "held ea", int'(ea), e_ea);
    chk("R11", "held err", int'(err), e_err);
    chk("R11", "idle no read", int'(mem_rd), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "done", int'(done), 0);
    chk("R12", "err", int'(err), 0);
    chk("R12", "direct", int'(direct), 0);
    chk("R12", "mem_rd", int'(mem_rd), 0);
    chk("R12", "ea", int'(ea), 0);
    chk("R12", "direct_val", int'(direct_val), 0);
    rst_n = 1'b1;
    run_op(0, 0, 8'h42, 8'h99, 1, 2, 0, 0);
    run_op(1, 0, 8'hFE, 8'h11, 0, 0, 0, 0);
    run_op(2, 0, 8'hFF, 0, 8'h01, 0, 0, 0);
    run_op(2, 1, 8'h80, 0, 8'h90, 0, 0, 0);
    run_op(3, 0, 8'hFF, 0, 0, 8'h01, 0, 0);
    run_op(3, 0, 8'h10, 0, 0, 8'h20, 0, 0);
    run_op(4, 0, 8'hCD, 8'hAB, 0, 0, 0, 0);
    run_op(5, 0, 8'hF0, 8'h12, 8'h20, 0, 0, 0);
    run_op(6, 1, 8'hFF, 8'hFF, 0, 8'h02, 0, 0);
    run_op(7, 0, 8'h20, 0, 0, 0, 0, 0);
    run_op(7, 0, 8'hFF, 0, 0, 0, 0, 1);
    run_op(8, 0, 8'hFE, 0, 8'h01, 0, 0, 0);
    run_op(8, 0, 8'h40, 0, 8'hC0, 0, 0, 1);
    run_op(9, 0, 8'hFF, 0, 0, 8'hFF, 0, 0);
    run_op(9, 1, 8'h33, 0, 0, 8'h05, 0, 0);
    run_op(10, 0, 8'h11, 0, 0, 0, 8'h5A, 0);
    run_op(10, 1, 8'h11, 0, 0, 0, 8'hC3, 0);
    run_op(11, 0, 8'h77, 0, 0, 0, 0, 0);
    run_op(11, 1, 8'h77, 0, 0, 0, 0, 0);
    for (int m = 12; m <= 15; m++) run_op(m, 0, 8'h21, 8'h43, 1, 1, 0, 0);
    run_op(4, 0, 8'h01, 8'h02, 0, 0, 0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule